// File: doc/BRIEF.md
# Flat Page Table Address Translator

This block turns a virtual address into a physical address by walking a single-level page table kept in memory. A requester hands over a virtual address with a valid/ready handshake. The block splits the address into a virtual page number and a byte offset within the page. It forms the address of that page's table entry from a programmable table base, and fetches the entry over a simple request/response memory port whose latency may vary. There is no translation cache, so every translation costs exactly one table read.

Each table entry holds a valid flag in its top bit and a frame field in its low bits. A valid entry yields the frame joined with the untouched page offset. An invalid entry yields one of two faults. A zero frame field means the page was never allocated. A non-zero field means the page lives on backing store, and that field is returned as its disk location. A memory response flagged as an error yields a bus-error status. The result is held until the requester takes it. The table base is written through a strobe that is honoured only while the block is idle.

Top module: `pt_xlate`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, while `rsp_valid` and `mem_req_valid` are 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is high only in the idle state, and stays low from the accepting edge until the result has been taken.
- R3: For each accepted request the block raises `mem_req_valid` with `mem_req_addr` = table base + VPN × `PTE_BYTES`, where VPN = `req_vaddr[VA_W-1:OFF_W]`. The request and its address are held steady until `mem_req_ready` is seen.
- R4: If entry bit `MEM_DW-1` is 1, the status is 0 (ok) and `rsp_paddr` = {entry[`PA_W-OFF_W-1`:0], vaddr[`OFF_W-1`:0]}, with `rsp_disk` = 0.
- R5: If entry bit `MEM_DW-1` is 0 and entry[`PA_W-OFF_W-1`:0] is zero, the status is 1 (unallocated), and `rsp_paddr` and `rsp_disk` are both 0. Entry bits between the frame field and the valid bit have no effect.
- R6: If entry bit `MEM_DW-1` is 0 and the frame field is non-zero, the status is 2 (on disk), `rsp_disk` equals the frame field, and `rsp_paddr` is 0.
- R7: A memory response with `mem_rsp_err` set gives status 3 (bus error), with `rsp_paddr` and `rsp_disk` both 0, whatever the data.
- R8: `rsp_valid` and the result fields stay stable until `rsp_ready` is seen. The block then returns to idle.
- R9: `base_we` loads `base_wdata` into the table base only while idle, and the new base is used by the next translation. A strobe raised while busy has no effect.
- R10: No translation is reused. Translating the same address twice issues two table reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_we | input | 1 | Table base write strobe |
| base_wdata | input | PA_W | New table base |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can take a request |
| req_vaddr | input | VA_W | Virtual address to translate |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_status | output | 2 | 0 ok, 1 unallocated, 2 on disk, 3 bus error |
| rsp_paddr | output | PA_W | Physical address (status 0 only) |
| rsp_disk | output | PA_W-OFF_W | Backing-store location (status 2 only) |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | PA_W | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | MEM_DW | Table entry |
| mem_rsp_err | input | 1 | Read failed |

## Verification
The translation path is driven with entries of every kind: valid frames at zero, mid-range and all-ones, and a zero invalid entry whose unused middle bits are set, so that a decoder reading those bits shows up. It also uses a non-zero invalid entry and an error response that carries data which would otherwise look valid. Page numbers at 0, mid-range and the maximum check the entry address arithmetic at both ends. Memory stalls and response latencies rotate between requests, and the requester sometimes delays taking a result, so that hold behaviour is separated from the timing of the table reads. Base writes made while idle and while busy show whether the idle-only rule is kept.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;

   typedef enum logic [1:0] {
      WS_IDLE  = 2'd0,
      WS_ISSUE = 2'd1,
      WS_WAIT  = 2'd2,
      WS_DONE  = 2'd3
   } walk_state_e;

   typedef enum logic [1:0] {
      XS_OK      = 2'd0,
      XS_UNALLOC = 2'd1,
      XS_ONDISK  = 2'd2,
      XS_BUSERR  = 2'd3
   } xlate_status_e;

endpackage

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
   import pt_xlate_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        mem_req_ready,
   input  logic        mem_rsp_valid,
   input  logic        rsp_ready,
   output walk_state_e state,
   output logic        idle,
   output logic        accept,
   output logic        capture,
   output logic        issuing,
   output logic        done
);

   walk_state_e state_nx;

   always_comb begin
      state_nx = state;
      unique case (state)
         WS_IDLE:  if (req_valid)     state_nx = WS_ISSUE;
         WS_ISSUE: if (mem_req_ready) state_nx = WS_WAIT;
         WS_WAIT:  if (mem_rsp_valid) state_nx = WS_DONE;
         WS_DONE:  if (rsp_ready)     state_nx = WS_IDLE;
         default:                     state_nx = WS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= WS_IDLE;
      else        state <= state_nx;
   end

   assign idle    = (state == WS_IDLE);
   assign issuing = (state == WS_ISSUE);
   assign done    = (state == WS_DONE);
   assign accept  = idle && req_valid;
   assign capture = (state == WS_WAIT) && mem_rsp_valid;

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !req_valid) |=> idle);

   // R8
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !rsp_ready) |=> done);

   // R3
   issue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issuing && !mem_req_ready) |=> issuing);

endmodule

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
   parameter int VPN_W     = 20,
   parameter int PA_W      = 32,
   parameter int PTE_BYTES = 4
) (
   input  logic [PA_W-1:0]  base,
   input  logic [VPN_W-1:0] vpn,
   output logic [PA_W-1:0]  entry_addr
);

   localparam bit IS_POW2 = (PTE_BYTES & (PTE_BYTES - 1)) == 0;
   localparam int SHIFT   = $clog2(PTE_BYTES);

   logic [PA_W-1:0] vpn_ext;
   assign vpn_ext = PA_W'(vpn);

   initial begin
      entry_size_chk: assert (PTE_BYTES >= 1)
         else $error("entry size must be at least one byte");
      vpn_width_chk: assert (VPN_W <= PA_W)
         else $error("page number wider than physical address");
   end

   generate
      if (IS_POW2) begin : g_shift
         assign entry_addr = base + (vpn_ext << SHIFT);
      end else begin : g_mult
         assign entry_addr = base + vpn_ext * PA_W'(PTE_BYTES);
      end
   endgenerate

endmodule

// File: rtl/pt_entry_decode.sv
module pt_entry_decode
   import pt_xlate_pkg::*;
#(
   parameter int MEM_DW  = 32,
   parameter int PA_W    = 32,
   parameter int OFF_W   = 12,
   parameter int FRAME_W = PA_W - OFF_W
) (
   input  logic [MEM_DW-1:0]  entry,
   input  logic               bus_err,
   input  logic [OFF_W-1:0]   offset,
   output xlate_status_e      status,
   output logic [PA_W-1:0]    paddr,
   output logic [FRAME_W-1:0] disk_loc
);

   localparam int GAP_W = MEM_DW - 1 - FRAME_W;

   logic               present;
   logic [FRAME_W-1:0] frame;
   logic               frame_zero;

   initial begin
      frame_fit_chk: assert (FRAME_W <= MEM_DW - 1)
         else $error("frame field and valid flag do not fit in an entry");
      frame_width_chk: assert (FRAME_W == PA_W - OFF_W)
         else $error("frame field must fill the physical page number");
   end

   assign present    = entry[MEM_DW-1];
   assign frame      = entry[FRAME_W-1:0];
   assign frame_zero = (frame == '0);

   generate
      if (GAP_W > 0) begin : g_gap
         logic unused_gap;
         assign unused_gap = ^entry[MEM_DW-2:FRAME_W];
      end
   endgenerate

   always_comb begin
      status   = XS_OK;
      paddr    = '0;
      disk_loc = '0;
      if (bus_err) begin
         status = XS_BUSERR;
      end else if (present) begin
         status = XS_OK;
         paddr  = {frame, offset};
      end else if (frame_zero) begin
         status = XS_UNALLOC;
      end else begin
         status   = XS_ONDISK;
         disk_loc = frame;
      end
   end

endmodule

// File: rtl/pt_xlate.sv
module pt_xlate
   import pt_xlate_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int OFF_W     = 12,
   parameter int PTE_BYTES = 4,
   parameter int MEM_DW    = 32,
   localparam int VPN_W    = VA_W - OFF_W,
   localparam int FRAME_W  = PA_W - OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               base_we,
   input  logic [PA_W-1:0]    base_wdata,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [VA_W-1:0]    req_vaddr,
   output logic               rsp_valid,
   input  logic               rsp_ready,
   output logic [1:0]         rsp_status,
   output logic [PA_W-1:0]    rsp_paddr,
   output logic [FRAME_W-1:0] rsp_disk,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [PA_W-1:0]    mem_req_addr,
   input  logic               mem_rsp_valid,
   input  logic [MEM_DW-1:0]  mem_rsp_data,
   input  logic               mem_rsp_err
);

   initial begin
      offset_width_chk: assert (OFF_W > 0 && OFF_W < VA_W && OFF_W < PA_W)
         else $error("page offset width out of range");
      entry_width_chk: assert (MEM_DW == 8 * PTE_BYTES)
         else $error("memory data width must equal the entry size");
   end

   walk_state_e     state;
   logic            idle, accept, capture, issuing, done;
   logic [PA_W-1:0] base_q;
   logic [VA_W-1:0] vaddr_q;

   xlate_status_e      dec_status;
   logic [PA_W-1:0]    dec_paddr;
   logic [FRAME_W-1:0] dec_disk;

   xlate_status_e      status_q;
   logic [PA_W-1:0]    paddr_q;
   logic [FRAME_W-1:0] disk_q;

   pt_walk_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .rsp_ready     (rsp_ready),
      .state         (state),
      .idle          (idle),
      .accept        (accept),
      .capture       (capture),
      .issuing       (issuing),
      .done          (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                base_q <= '0;
      else if (base_we && idle)  base_q <= base_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vaddr_q <= '0;
      else if (accept) vaddr_q <= req_vaddr;
   end

   pt_entry_addr #(
      .VPN_W     (VPN_W),
      .PA_W      (PA_W),
      .PTE_BYTES (PTE_BYTES)
   ) u_addr (
      .base       (base_q),
      .vpn        (vaddr_q[VA_W-1:OFF_W]),
      .entry_addr (mem_req_addr)
   );

   pt_entry_decode #(
      .MEM_DW  (MEM_DW),
      .PA_W    (PA_W),
      .OFF_W   (OFF_W),
      .FRAME_W (FRAME_W)
   ) u_dec (
      .entry    (mem_rsp_data),
      .bus_err  (mem_rsp_err),
      .offset   (vaddr_q[OFF_W-1:0]),
      .status   (dec_status),
      .paddr    (dec_paddr),
      .disk_loc (dec_disk)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= XS_OK;
         paddr_q  <= '0;
         disk_q   <= '0;
      end else if (capture) begin
         status_q <= dec_status;
         paddr_q  <= dec_paddr;
         disk_q   <= dec_disk;
      end
   end

   assign req_ready     = idle;
   assign mem_req_valid = issuing;
   assign rsp_valid     = done;
   assign rsp_status    = status_q;
   assign rsp_paddr     = paddr_q;
   assign rsp_disk      = disk_q;

   // R2
   busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!rsp_valid && !mem_req_valid));

   // R3
   mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R8
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=>
         (rsp_valid && $stable(rsp_status) && $stable(rsp_paddr) && $stable(rsp_disk)));

   // R4
   ok_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == XS_OK) |->
         (rsp_paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0] && rsp_disk == '0));

   // R5
   unalloc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == XS_UNALLOC) |-> (rsp_paddr == '0 && rsp_disk == '0));

   // R6
   ondisk_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == XS_ONDISK) |-> (rsp_paddr == '0 && rsp_disk != '0));

   // R7
   buserr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == XS_BUSERR) |-> (rsp_paddr == '0 && rsp_disk == '0));

   // R9
   base_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> $stable(base_q));

endmodule

// File: tb/pt_xlate_bench.sv
`timescale 1ns/1ps
module pt_xlate_bench;

   localparam int VA_W      = 32;
   localparam int PA_W      = 32;
   localparam int OFF_W     = 12;
   localparam int PTE_BYTES = 4;
   localparam int MEM_DW    = 32;
   localparam int FRAME_W   = PA_W - OFF_W;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               base_we = 1'b0;
   logic [PA_W-1:0]    base_wdata = '0;
   logic               req_valid = 1'b0;
   logic               req_ready;
   logic [VA_W-1:0]    req_vaddr = '0;
   logic               rsp_valid;
   logic               rsp_ready = 1'b0;
   logic [1:0]         rsp_status;
   logic [PA_W-1:0]    rsp_paddr;
   logic [FRAME_W-1:0] rsp_disk;
   logic               mem_req_valid;
   logic               mem_req_ready = 1'b0;
   logic [PA_W-1:0]    mem_req_addr;
   logic               mem_rsp_valid = 1'b0;
   logic [MEM_DW-1:0]  mem_rsp_data = '0;
   logic               mem_rsp_err = 1'b0;

   always #2.5 clk = ~clk;

   pt_xlate u_pt_xlate (
      .clk           (clk),
      .rst_n         (rst_n),
      .base_we       (base_we),
      .base_wdata    (base_wdata),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_vaddr     (req_vaddr),
      .rsp_valid     (rsp_valid),
      .rsp_ready     (rsp_ready),
      .rsp_status    (rsp_status),
      .rsp_paddr     (rsp_paddr),
      .rsp_disk      (rsp_disk),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .mem_rsp_err   (mem_rsp_err)
   );

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // table memory held by the bench
   logic [MEM_DW-1:0] tbl [logic [PA_W-1:0]];
   bit                tbl_err [logic [PA_W-1:0]];

   // reference model: 0 idle, 1 read issued, 2 awaiting data, 3 result held
   int              m_ph = 0;
   logic [PA_W-1:0] m_base = '0;
   logic [VA_W-1:0] m_va = '0;
   int              m_acc = 0;
   int              m_reads = 0;
   logic [1:0]      e_status = '0;
   logic [PA_W-1:0] e_paddr = '0;
   logic [FRAME_W-1:0] e_disk = '0;
   logic [PA_W-1:0] pend_addr = '0;
   int              rlat = 0;

   function automatic logic [PA_W-1:0] ent_addr(input logic [PA_W-1:0] b,
                                                input logic [VA_W-1:0] va);
      longint unsigned vpn;
      vpn = longint'(va >> OFF_W);
      return PA_W'(longint'(b) + vpn * PTE_BYTES);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0;
         m_base = '0;
      end else begin
         case (m_ph)
            0: begin
               if (base_we) m_base = base_wdata;
               if (req_valid) begin
                  m_va = req_vaddr;
                  m_acc++;
                  m_ph = 1;
               end
            end
            1: if (mem_req_ready) begin
               pend_addr = ent_addr(m_base, m_va);
               rlat = 1 + (m_reads % 4);
               m_reads++;
               m_ph = 2;
            end
            2: if (mem_rsp_valid) begin
               e_status = 2'd0; e_paddr = '0; e_disk = '0;
               if (mem_rsp_err) e_status = 2'd3;
               else if (mem_rsp_data[MEM_DW-1]) begin
                  e_status = 2'd0;
                  e_paddr = {mem_rsp_data[FRAME_W-1:0], m_va[OFF_W-1:0]};
               end else if (mem_rsp_data[FRAME_W-1:0] == '0) e_status = 2'd1;
               else begin
                  e_status = 2'd2;
                  e_disk = mem_rsp_data[FRAME_W-1:0];
               end
               m_ph = 3;
            end
            default: if (rsp_ready) m_ph = 0;
         endcase
      end
   end

   // memory side stimulus and per-cycle comparison
   always @(negedge clk) begin
      cyc++;
      mem_req_ready <= (cyc % 3) != 1;
      mem_rsp_valid <= 1'b0;
      mem_rsp_err   <= 1'b0;
      if (rlat > 0) begin
         rlat--;
         if (rlat == 0) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= tbl.exists(pend_addr) ? tbl[pend_addr] : '0;
            mem_rsp_err   <= tbl_err.exists(pend_addr);
         end
      end
      if (rst_n) begin
         check(req_ready == (m_ph == 0), "R2 req_ready", 64'(req_ready), 64'(m_ph == 0));
         check(mem_req_valid == (m_ph == 1), "R3 mem_req_valid",
               64'(mem_req_valid), 64'(m_ph == 1));
         if (m_ph == 1)
            check(mem_req_addr == ent_addr(m_base, m_va), "R3/R9 mem_req_addr",
                  64'(mem_req_addr), 64'(ent_addr(m_base, m_va)));
         check(rsp_valid == (m_ph == 3), "R8 rsp_valid", 64'(rsp_valid), 64'(m_ph == 3));
         if (m_ph == 3) begin
            check(rsp_status == e_status, "R4-7 status", 64'(rsp_status), 64'(e_status));
            check(rsp_paddr == e_paddr, "R4 paddr", 64'(rsp_paddr), 64'(e_paddr));
            check(rsp_disk == e_disk, "R6 disk", 64'(rsp_disk), 64'(e_disk));
         end
      end
   end

   task automatic write_base(input logic [PA_W-1:0] b);
      @(negedge clk);
      base_we = 1'b1; base_wdata = b;
      @(negedge clk);
      base_we = 1'b0;
   endtask

   task automatic translate(input logic [VA_W-1:0] va, input int hold,
                            input bit busy_poke, input logic [1:0] want);
      int acc0;
      acc0 = m_acc;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va;
      while (m_acc == acc0) @(negedge clk);
      req_valid = 1'b0;
      req_vaddr = ~va;
      if (busy_poke) begin
         base_we = 1'b1; base_wdata = 32'hDEAD_0000;
         @(negedge clk);
         base_we = 1'b0;
      end
      while (m_ph != 3) @(negedge clk);
      // explicit per-case status check
      check(rsp_status == want, "R4/R5/R6/R7 case status", 64'(rsp_status), 64'(want));
      repeat (hold) @(negedge clk);
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
   endtask

   function automatic logic [VA_W-1:0] mkva(input int vpn, input int off);
      return VA_W'((longint'(vpn) << OFF_W) | longint'(off));
   endfunction

   initial begin
      int reads0;
      logic [PA_W-1:0] b0;
      b0 = 32'h1000_0000;
      tbl[ent_addr(b0, mkva(5, 0))]       = 32'h800A_BCDE;
      tbl[ent_addr(b0, mkva(6, 0))]       = 32'h7FF0_0000;
      tbl[ent_addr(b0, mkva(7, 0))]       = 32'h0001_2345;
      tbl[ent_addr(b0, mkva(8, 0))]       = 32'h8005_5555;
      tbl_err[ent_addr(b0, mkva(8, 0))]   = 1'b1;
      tbl[ent_addr(b0, mkva(0, 0))]       = 32'h8000_0000;
      tbl[ent_addr(b0, mkva(20'hFFFFF, 0))] = 32'h800F_FFFF;
      tbl[ent_addr(32'h2000_0000, mkva(5, 0))] = 32'h8001_1111;

      repeat (3) @(negedge clk);
      // R1 reset state
      check(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
      check(rsp_valid == 1'b0, "R1 rsp_valid", 64'(rsp_valid), 64'd0);
      check(mem_req_valid == 1'b0, "R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1, "R1 idle after release", 64'(req_ready), 64'd1);

      write_base(b0);                               // R9 idle write
      translate(mkva(5, 12'h3A7), 0, 1'b0, 2'd0);   // R4
      translate(mkva(6, 12'hFFF), 2, 1'b0, 2'd1);   // R5 with junk middle bits
      translate(mkva(7, 12'h001), 0, 1'b0, 2'd2);   // R6
      translate(mkva(8, 12'h123), 3, 1'b0, 2'd3);   // R7 error over valid data
      translate(mkva(0, 12'h000), 1, 1'b0, 2'd0);   // R3 lowest page
      translate(mkva(20'hFFFFF, 12'hFFF), 0, 1'b1, 2'd0); // R3 top page, R9 busy poke
      translate(mkva(9, 12'h010), 0, 1'b0, 2'd1);   // R5 empty slot
      reads0 = m_reads;
      translate(mkva(5, 12'h004), 4, 1'b1, 2'd0);   // R10 repeat, R8 long hold
      translate(mkva(5, 12'h004), 0, 1'b0, 2'd0);
      check(m_reads - reads0 == 2, "R10 table reads", 64'(m_reads - reads0), 64'd2);
      write_base(32'h2000_0000);                    // R9 new base applies
      translate(mkva(5, 12'h777), 0, 1'b0, 2'd0);
      repeat (5) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule